// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Pulse Frame

This block is a 4 KB register frame that converts message-signalled interrupt doorbell writes into single-cycle pulses on a bank of shared peripheral interrupt lines. A device or bridge writes an interrupt number into the doorbell register. If the number lies inside the window that the frame serves, the line matching that number pulses high for exactly one clock. The frame does not latch anything, so the pulse is the whole event.

Software finds out which window the frame serves by reading a type register. That register packs the first interrupt number served (the base parameter plus 32) and the number of lines. An identification register returns a fixed product code, and a block of identification offsets at the top of the window reads as zero. The register bus is a plain 32-bit interface with a byte offset, read and write strobes, and an access size in bytes. Read data and the error flag are registered, so both appear one cycle after the strobe.

Two parameters set the window: `BASE_NUM` and `LINE_CNT`. They are checked during elaboration. The line count must be at most 128, and `BASE_NUM + 32 + LINE_CNT` must be at most 1020. Either violation stops the build with an error.

Top module: `msi_spi_frame`

## Requirements
- R1: A 4-byte read at offset 0x008 returns `BASE_NUM+32` in bits [31:16] and `LINE_CNT` in bits [15:0] on `bus_rdata` in the cycle after the read strobe.
- R2: A write of size 2 or 4 at offset 0x040 uses `bus_wdata[9:0]` as an interrupt number N. When `BASE_NUM+32 <= N < BASE_NUM+32+LINE_CNT`, bit `N-BASE_NUM-32` of `spi_pulse` is high for exactly the one cycle after the write.
- R3: A doorbell number below `BASE_NUM+32`, or at or above `BASE_NUM+32+LINE_CNT`, produces no pulse on any line. Bits [31:10] of the written data never affect which line is chosen.
- R4: Doorbell writes on consecutive cycles produce pulses on consecutive cycles, including repeated writes of the same number. At most one line is high in any cycle.
- R5: A 4-byte read at offset 0xFCC returns 0x05100000, which is product code 0x51 in bits [31:20] with all other fields zero.
- R6: A 4-byte read at any offset from 0xFD0 through 0xFFC returns zero.
- R7: A read whose size is not 4 returns zero. A doorbell write whose size is neither 2 nor 4 produces no pulse.
- R8: An access to an offset that has no register for that direction sets `bad_access` high for the one cycle after the access. This covers reads outside 0x008, 0xFCC and 0xFD0–0xFFF, and writes anywhere except 0x040. Such a read returns zero, and such a write produces no pulse.
- R9: While the synchronous active-high reset `rst` is high, `spi_pulse`, `bus_rdata` and `bad_access` are zero in the cycle after each reset edge, and no access has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset into the 4 KB frame |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| spi_pulse | output | LINE_CNT | One-cycle interrupt pulses, bit i serves number `BASE_NUM+32+i` |
| bad_access | output | 1 | One-cycle flag for an access to an undecoded offset |

## Verification
Every result of this frame is due exactly one cycle after the strobe that caused it: the doorbell pulse, the read data and the error flag. The bench drives a stimulus on the falling edge, and its reference model predicts all three outputs for the following rising edge. It then compares them on the next falling edge, before driving the next stimulus, so every output is checked in every cycle. Back-to-back doorbells rely on this: each cycle's pulse is checked against the write made just one edge earlier.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_W  = 10;

  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_SET   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_IDLO  = 12'hFD0;

  localparam logic [11:0] PRODUCT_CODE = 12'h051;
  localparam int MAX_LINES = 128;
  localparam int MAX_NUM   = 1020;

  // Packed window description: first served number high, count low.
  function automatic logic [DATA_W-1:0] type_word(input int first, input int cnt);
    logic [15:0] hi;
    logic [15:0] lo;
    hi = first[15:0];
    lo = cnt[15:0];
    return {hi, lo};
  endfunction

  function automatic logic [DATA_W-1:0] ident_word();
    return {PRODUCT_CODE, 20'h0_0000};
  endfunction

  function automatic logic in_window(input logic [NUM_W-1:0] num,
                                     input int first, input int cnt);
    int n;
    n = int'(num);
    return (n >= first) && (n < first + cnt);
  endfunction

  function automatic logic size_ok_wr(input logic [2:0] sz);
    return (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_frame_pkg::*;
#(
  parameter int FIRST    = 32,
  parameter int LINE_CNT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [2:0]        size,
  output logic [DATA_W-1:0] rdata,
  output logic              bad_access
);
  logic              rd_known;
  logic              wr_known;
  logic              rd_full;
  logic [DATA_W-1:0] rd_val;

  assign rd_known = (addr == OFS_TYPE) || (addr == OFS_IDENT) || (addr >= OFS_IDLO);
  assign wr_known = (addr == OFS_SET);
  assign rd_full  = (size == 3'd4);

  always_comb begin
    rd_val = '0;
    if (addr == OFS_TYPE)       rd_val = type_word(FIRST, LINE_CNT);
    else if (addr == OFS_IDENT) rd_val = ident_word();
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      rdata      <= (rd && rd_full) ? rd_val : '0;
      bad_access <= (rd && !rd_known) || (wr && !wr_known);
    end
  end

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> $past(rd || wr)); // R8
  AST_RD_SIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && size != 3'd4) |=> (rdata == '0)); // R7
  AST_IDBLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && addr >= OFS_IDLO) |=> (rdata == '0)); // R6
  AST_IDENT_CODE: assert property (@(posedge clk) disable iff (rst)
    (rd && rd_full && addr == OFS_IDENT) |=> (rdata[31:20] == 12'h051 && rdata[19:0] == '0)); // R5
  AST_RD_ONLY_WHEN_STROBED: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0)); // R1
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_frame_pkg::*;
#(
  parameter int FIRST    = 32,
  parameter int LINE_CNT = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2:0]          size,
  input  logic [NUM_W-1:0]    num,
  output logic [LINE_CNT-1:0] pulse
);
  localparam logic [NUM_W-1:0] FIRST_N = NUM_W'(FIRST);

  logic             at_set;
  logic             num_hit;
  logic             set_hit;
  logic [NUM_W-1:0] idx;

  assign at_set  = wr && (addr == OFS_SET);
  assign num_hit = in_window(num, FIRST, LINE_CNT);
  assign set_hit = at_set && size_ok_wr(size) && num_hit;
  assign idx     = num - FIRST_N;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pulse[g] <= 1'b0;
      else     pulse[g] <= set_hit && (idx == NUM_W'(g));
    end
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse)); // R4
  AST_PULSE_FROM_DOORBELL: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |-> $past(wr && addr == OFS_SET)); // R2
  AST_OUT_OF_WINDOW_SILENT: assert property (@(posedge clk) disable iff (rst)
    (at_set && !num_hit) |=> (pulse == '0)); // R3
  AST_WR_SIZE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr && !size_ok_wr(size)) |=> (pulse == '0)); // R7
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    set_hit |=> (|pulse)); // R4
endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
  import msi_frame_pkg::*;
#(
  parameter int BASE_NUM = 0,
  parameter int LINE_CNT = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [11:0]         bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [2:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [LINE_CNT-1:0] spi_pulse,
  output logic                bad_access
);
  localparam int FIRST = BASE_NUM + 32;

  if (LINE_CNT > MAX_LINES) begin : g_cnt_chk
    $error("msi_spi_frame: LINE_CNT exceeds 128");
  end
  if (FIRST + LINE_CNT > MAX_NUM) begin : g_top_chk
    $error("msi_spi_frame: window ends beyond interrupt number 1020");
  end

  msi_reg_decode #(.FIRST(FIRST), .LINE_CNT(LINE_CNT)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .size       (bus_size),
    .rdata      (bus_rdata),
    .bad_access (bad_access)
  );

  msi_doorbell #(.FIRST(FIRST), .LINE_CNT(LINE_CNT)) u_doorbell (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .size  (bus_size),
    .num   (bus_wdata[NUM_W-1:0]),
    .pulse (spi_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (spi_pulse == '0 && bus_rdata == '0 && !bad_access)); // R9
endmodule

// File: tb/msi_spi_frame_bench.sv
module msi_spi_frame_bench;
  localparam int TB_BASE = 3;
  localparam int TB_CNT  = 40;
  localparam int FIRST   = TB_BASE + 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [11:0]       bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [2:0]        bus_size = 3'd4;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [TB_CNT-1:0] spi_pulse;
  logic              bad_access;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [TB_CNT-1:0] exp_pulse = '0;
  logic [31:0]       exp_rdata = '0;
  logic              exp_err   = 1'b0;
  string             exp_tag   = "R9";

  always #4 clk = ~clk;

  msi_spi_frame #(.BASE_NUM(TB_BASE), .LINE_CNT(TB_CNT)) u_msi_spi_frame (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_pulse(spi_pulse), .bad_access(bad_access)
  );

  task automatic compare();
    checks += 3;
    if (spi_pulse !== exp_pulse) begin
      fails++;
      $display("FAIL %s spi_pulse actual=%h expected=%h", exp_tag, spi_pulse, exp_pulse);
    end
    if (bus_rdata !== exp_rdata) begin
      fails++;
      $display("FAIL %s bus_rdata actual=%h expected=%h", exp_tag, bus_rdata, exp_rdata);
    end
    if (bad_access !== exp_err) begin
      fails++;
      $display("FAIL %s bad_access actual=%b expected=%b", exp_tag, bad_access, exp_err);
    end
  endtask

  // Behavioural model of the next edge, from the requirements.
  task automatic predict();
    int n;
    exp_pulse = '0;
    exp_rdata = '0;
    exp_err   = 1'b0;
    if (rst) return;
    if (bus_wr) begin
      if (bus_addr == 12'h040) begin
        n = int'(bus_wdata) & 1023;
        if ((bus_size == 3'd2 || bus_size == 3'd4) && n >= FIRST && n < FIRST + TB_CNT)
          exp_pulse[n - FIRST] = 1'b1;
      end else begin
        exp_err = 1'b1;
      end
    end
    if (bus_rd) begin
      if (!(bus_addr == 12'h008 || bus_addr == 12'hFCC || int'(bus_addr) >= 'hFD0))
        exp_err = 1'b1;
      if (bus_size == 3'd4) begin
        if (bus_addr == 12'h008)      exp_rdata = (FIRST * 65536) + TB_CNT;
        else if (bus_addr == 12'hFCC) exp_rdata = 32'h0510_0000;
      end
    end
  endtask

  task automatic step(input logic r, input logic [11:0] a, input logic w, input logic rd,
                      input logic [2:0] sz, input logic [31:0] d, input string tag);
    @(negedge clk);
    compare();
    rst = r; bus_addr = a; bus_wr = w; bus_rd = rd; bus_size = sz; bus_wdata = d;
    exp_tag = tag;
    predict();
  endtask

  task automatic ring(input int n, input logic [2:0] sz, input string tag);
    step(1'b0, 12'h040, 1'b1, 1'b0, sz, 32'(n), tag);
  endtask

  task automatic rd4(input logic [11:0] a, input string tag);
    step(1'b0, a, 1'b0, 1'b1, 3'd4, 32'h0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 12'h000, 1'b0, 1'b0, 3'd4, 32'h0, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    // R9: reset, including an access made while reset is high
    step(1'b1, 12'h000, 1'b0, 1'b0, 3'd4, 0, "R9");
    step(1'b1, 12'h040, 1'b1, 1'b0, 3'd4, 32'(FIRST), "R9");
    step(1'b1, 12'h008, 1'b0, 1'b1, 3'd4, 0, "R9");
    idle("R9");
    // R1 type register
    rd4(12'h008, "R1");
    idle("R1");
    // R5 identification, R6 zero block
    rd4(12'hFCC, "R5");
    rd4(12'hFD0, "R6");
    rd4(12'hFE4, "R6");
    rd4(12'hFFC, "R6");
    // R7 narrow reads return zero
    step(1'b0, 12'h008, 1'b0, 1'b1, 3'd2, 0, "R7");
    step(1'b0, 12'hFCC, 1'b0, 1'b1, 3'd1, 0, "R7");
    // R2 window edges and middle, both sizes
    ring(FIRST, 3'd4, "R2");
    idle("R2");
    ring(FIRST + TB_CNT - 1, 3'd4, "R2");
    ring(FIRST + 7, 3'd2, "R2");
    idle("R2");
    // R3 just outside, zero, max, upper data bits ignored
    ring(FIRST - 1, 3'd4, "R3");
    ring(FIRST + TB_CNT, 3'd4, "R3");
    ring(0, 3'd4, "R3");
    ring(1023, 3'd4, "R3");
    step(1'b0, 12'h040, 1'b1, 1'b0, 3'd4, 32'hFFFF_FC00 | 32'(FIRST + 5), "R3");
    step(1'b0, 12'h040, 1'b1, 1'b0, 3'd4, 32'h0000_0400 | 32'(FIRST - 2), "R3");
    // R7 bad write sizes dropped
    ring(FIRST + 3, 3'd1, "R7");
    ring(FIRST + 3, 3'd3, "R7");
    idle("R7");
    // R4 back-to-back, same number then neighbours
    ring(FIRST + 10, 3'd4, "R4");
    ring(FIRST + 10, 3'd4, "R4");
    ring(FIRST + 11, 3'd4, "R4");
    ring(FIRST + 12, 3'd2, "R4");
    idle("R4");
    // R8 undecoded accesses
    step(1'b0, 12'h008, 1'b1, 1'b0, 3'd4, 32'(FIRST), "R8");
    step(1'b0, 12'hFCC, 1'b1, 1'b0, 3'd4, 32'(FIRST), "R8");
    rd4(12'h040, "R8");
    rd4(12'h100, "R8");
    step(1'b0, 12'h044, 1'b1, 1'b0, 3'd4, 32'(FIRST + 1), "R8");
    step(1'b0, 12'h004, 1'b0, 1'b1, 3'd2, 0, "R8");
    idle("R8");
    // R9 reset during a stream of doorbells
    ring(FIRST + 2, 3'd4, "R4");
    step(1'b1, 12'h040, 1'b1, 1'b0, 3'd4, 32'(FIRST + 3), "R9");
    idle("R9");
    // Mixed traffic across all requirements
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: a = 12'h040;
        3'd3: a = 12'h008;
        3'd4: a = 12'hFCC;
        3'd5: a = {8'hFF, lfsr[7:6], 2'b00};
        default: a = {lfsr[11:4], 4'h0};
      endcase
      step(1'b0, a, lfsr[3], !lfsr[3] || lfsr[4], lfsr[5] ? 3'd4 : (lfsr[6] ? 3'd2 : 3'd1),
           32'(FIRST - 4 + int'(lfsr[13:8] % 6'd48)) | {lfsr[15:14], 30'h0}, "R2");
    end
    idle("R2");
    idle("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule